// File: doc/BRIEF.md
# GF(2^163) Karatsuba Field Multiplier

This block computes the product of two 163-bit binary-field elements in polynomial basis and reduces it modulo x^163 + x^7 + x^6 + x^3 + 1. The carry-less product comes from a recursive Karatsuba tree. Each level splits its operands into a high half and a low half, and the recursion stops when the pieces are 11 or 10 bits wide. At that point a plain partial-product array forms the leaf products. A fixed XOR fold then reduces the 325-bit raw product to 163 bits.

A squaring mode bypasses the multiplier tree. It spreads operand A over the even bit positions of a 325-bit word and sends that word through the same reduction fold. The caller presents the operands together with a one-cycle start strobe. The reduced result is registered at that clock edge and is announced by a one-cycle done strobe. The result then holds until the next start.

Top module: `gf163_kmul`

## Requirements
- R1: After synchronous reset, `done` is 0 and `result` is all zeros.
- R2: With `sq_mode`=0, a start produces `result` = `op_a`·`op_b` mod (x^163+x^7+x^6+x^3+1). Bit i of each bus is the coefficient of x^i.
- R3: Multiplying any operand by the element 1 (only bit 0 set) returns that operand unchanged, in either operand order.
- R4: If either operand is zero, the result is zero.
- R5: All-ones operands, which give the highest-degree raw product, are fully reduced to the correct 163-bit value.
- R6: Multiplying x^162 (only bit 162 set) by x (only bit 1 set) yields x^7+x^6+x^3+1, which is 0xC9 in the low bits.
- R7: With `sq_mode`=1, a start produces `result` = `op_a`² mod the field polynomial. The value of `op_b` has no effect.
- R8: `done` is high in exactly the cycle after each cycle in which `start` was high, and is low otherwise.
- R9: When `start` is low, `result` holds its value regardless of changes on `op_a`, `op_b` or `sq_mode`.
- R10: Starts in consecutive cycles each produce their own correct result, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request strobe; operands are sampled with it |
| sq_mode | input | 1 | 0 = multiply A·B, 1 = square A |
| op_a | input | 163 | Operand A, bit i = coefficient of x^i |
| op_b | input | 163 | Operand B (ignored in square mode) |
| result | output | 163 | Reduced field result, held until the next start |
| done | output | 1 | High for one cycle when `result` carries a new value |

## Verification
Every result is due exactly one clock edge after the edge that samples `start`. The bench raises `start` on a falling edge. It then reads `done` and `result` on the next falling edge, which is half a period after the capturing rising edge. One more falling edge later it confirms that `done` has dropped. In the hold and back-to-back scenarios the bench keeps the same half-period offset. It compares every value against its own bit-serial shift-and-reduce model.

// File: rtl/gf163_pkg.sv
package gf163_pkg;

    localparam int FIELD_M = 163;
    localparam int WIDE_W  = 2 * FIELD_M - 1;
    localparam int LEAF_W  = 11;

    // middle terms of the field polynomial (x^163 and 1 are implicit)
    localparam int TAP_HI  = 7;
    localparam int TAP_MID = 6;
    localparam int TAP_LO  = 3;

    typedef logic [FIELD_M-1:0] fe_t;
    typedef logic [WIDE_W-1:0]  wide_t;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_SQR = 1'b1
    } op_e;

    typedef struct packed {
        op_e op;
        fe_t a;
        fe_t b;
    } req_t;

    // squaring over GF(2): coefficient i moves to position 2i
    function automatic wide_t spread_even(input fe_t v);
        wide_t s;
        s = '0;
        for (int i = 0; i < FIELD_M; i++) begin
            s[2*i] = v[i];
        end
        return s;
    endfunction

endpackage

// File: rtl/gf163_leaf_mul.sv
module gf163_leaf_mul #(
    parameter int W = 11
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-2:0] p
);
    localparam int PW = 2 * W - 1;

    logic [PW-1:0] a_ext;
    logic [PW-1:0] acc;

    assign a_ext = PW'(a);

    always_comb begin
        acc = '0;
        for (int i = 0; i < W; i++) begin
            if (b[i]) begin
                acc = acc ^ (a_ext << i);
            end
        end
    end

    assign p = acc;

endmodule

// File: rtl/gf163_kara.sv
module gf163_kara #(
    parameter int W    = 163,
    parameter int LEAF = 11
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-2:0] p
);
    localparam int PW = 2 * W - 1;

    generate
        if (W <= LEAF) begin : g_leaf
            gf163_leaf_mul #(.W(W)) u_leaf (
                .a(a),
                .b(b),
                .p(p)
            );
        end else begin : g_split
            localparam int H  = (W + 1) / 2;
            localparam int L  = W - H;
            localparam int HP = 2 * H - 1;
            localparam int LP = 2 * L - 1;

            logic [H-1:0]  a_lo, b_lo, a_sum, b_sum;
            logic [L-1:0]  a_hi, b_hi;
            logic [HP-1:0] p_lo, p_sum, p_mid;
            logic [LP-1:0] p_hi;

            assign a_lo  = a[H-1:0];
            assign b_lo  = b[H-1:0];
            assign a_hi  = a[W-1:H];
            assign b_hi  = b[W-1:H];
            assign a_sum = a_lo ^ H'(a_hi);
            assign b_sum = b_lo ^ H'(b_hi);

            gf163_kara #(.W(H), .LEAF(LEAF)) u_lo (
                .a(a_lo), .b(b_lo), .p(p_lo)
            );
            gf163_kara #(.W(L), .LEAF(LEAF)) u_hi (
                .a(a_hi), .b(b_hi), .p(p_hi)
            );
            gf163_kara #(.W(H), .LEAF(LEAF)) u_sum (
                .a(a_sum), .b(b_sum), .p(p_sum)
            );

            // cross term = (a_lo+a_hi)(b_lo+b_hi) - lo - hi
            assign p_mid = p_sum ^ p_lo ^ HP'(p_hi);

            assign p = (PW'(p_hi) << (2 * H)) ^ (PW'(p_mid) << H) ^ PW'(p_lo);
        end
    endgenerate

endmodule

// File: rtl/gf163_fold.sv
module gf163_fold
    import gf163_pkg::*;
(
    input  wide_t raw,
    output fe_t   red
);
    wide_t work;

    // fold from the top bit down; each set bit x^i becomes
    // x^(i-163) * (x^7 + x^6 + x^3 + 1)
    always_comb begin
        work = raw;
        for (int i = WIDE_W - 1; i >= FIELD_M; i--) begin
            if (work[i]) begin
                work[i - FIELD_M + TAP_HI]  = ~work[i - FIELD_M + TAP_HI];
                work[i - FIELD_M + TAP_MID] = ~work[i - FIELD_M + TAP_MID];
                work[i - FIELD_M + TAP_LO]  = ~work[i - FIELD_M + TAP_LO];
                work[i - FIELD_M]           = ~work[i - FIELD_M];
                work[i]                     = 1'b0;
            end
        end
    end

    assign red = work[FIELD_M-1:0];

    always_comb begin
        a_r1_fold_zero_in : assert (!(raw == '0) || (red == '0));
    end

endmodule

// File: rtl/gf163_kmul.sv
module gf163_kmul
    import gf163_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         sq_mode,
    input  logic [162:0] op_a,
    input  logic [162:0] op_b,
    output logic [162:0] result,
    output logic         done
);
    req_t  req;
    wide_t prod_raw;
    wide_t sqr_raw;
    wide_t fold_in;
    fe_t   fold_out;
    fe_t   res_q;
    logic  done_q;

    assign req = '{op: op_e'(sq_mode), a: op_a, b: op_b};

    gf163_kara #(.W(FIELD_M), .LEAF(LEAF_W)) u_tree (
        .a(req.a),
        .b(req.b),
        .p(prod_raw)
    );

    assign sqr_raw = spread_even(req.a);
    assign fold_in = (req.op == OP_SQR) ? sqr_raw : prod_raw;

    gf163_fold u_fold (
        .raw(fold_in),
        .red(fold_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= start;
            if (start) begin
                res_q <= fold_out;
            end
        end
    end

    assign result = res_q;
    assign done   = done_q;

    a_r1_reset_clears : assert property (@(posedge clk)
        rst |=> (!done && result == '0));

    a_r8_done_after_start : assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    a_r8_no_spurious_done : assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);

    a_r9_result_holds : assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(result));

endmodule

// File: tb/sim_gf163_kmul.sv
module sim_gf163_kmul;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         sq_mode = 1'b0;
    logic [162:0] op_a = '0;
    logic [162:0] op_b = '0;
    logic [162:0] result;
    logic         done;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    gf163_kmul u0 (
        .clk(clk), .rst(rst), .start(start), .sq_mode(sq_mode),
        .op_a(op_a), .op_b(op_b), .result(result), .done(done)
    );

    function automatic logic [162:0] ref_mul(input logic [162:0] a, input logic [162:0] b);
        logic [163:0] acc;
        acc = '0;
        for (int i = 162; i >= 0; i--) begin
            acc = acc << 1;
            if (acc[163]) acc = acc ^ {1'b1, 155'd0, 8'hC9};
            if (b[i]) acc[162:0] = acc[162:0] ^ a;
        end
        return acc[162:0];
    endfunction

    function automatic logic [162:0] rnd_fe();
        logic [191:0] w;
        w = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        return w[162:0];
    endfunction

    task automatic check(input bit ok, input string req, input logic [162:0] act,
                         input logic [162:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one request; checks done/result one edge later and done drop one edge after
    task automatic run_op(input logic sq, input logic [162:0] a, input logic [162:0] b,
                          input logic [162:0] exp, input string req);
        @(negedge clk);
        sq_mode = sq; op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1, "R8 done high", {162'd0, done}, 163'd1);
        check(result == exp, req, result, exp);
        @(negedge clk);
        check(done == 1'b0, "R8 done single cycle", {162'd0, done}, 163'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(done == 1'b0, "R1 done", {162'd0, done}, 163'd0);
        check(result == '0, "R1 result", result, '0);
    endtask

    task automatic t_identity();
        logic [162:0] v = rnd_fe();
        run_op(1'b0, v, 163'd1, v, "R3 a*1");
        run_op(1'b0, 163'd1, v, v, "R3 1*b");
    endtask

    task automatic t_zero();
        logic [162:0] v = rnd_fe();
        run_op(1'b0, v, '0, '0, "R4 a*0");
        run_op(1'b0, '0, v, '0, "R4 0*b");
    endtask

    task automatic t_allones();
        logic [162:0] ones = '1;
        run_op(1'b0, ones, ones, ref_mul(ones, ones), "R5 ones*ones");
    endtask

    task automatic t_top_fold();
        logic [162:0] hi = '0;
        hi[162] = 1'b1;
        run_op(1'b0, hi, 163'd2, 163'hC9, "R6 x^162*x");
    endtask

    task automatic t_random();
        for (int k = 0; k < 24; k++) begin
            logic [162:0] a = rnd_fe();
            logic [162:0] b = rnd_fe();
            run_op(1'b0, a, b, ref_mul(a, b), "R2 random product");
        end
    endtask

    task automatic t_square();
        for (int k = 0; k < 6; k++) begin
            logic [162:0] a = rnd_fe();
            run_op(1'b1, a, rnd_fe(), ref_mul(a, a), "R7 square ignores b");
        end
        run_op(1'b1, '1, '0, ref_mul('1, '1), "R7 square all ones");
    endtask

    task automatic t_hold();
        logic [162:0] a = rnd_fe();
        logic [162:0] b = rnd_fe();
        logic [162:0] e = ref_mul(a, b);
        run_op(1'b0, a, b, e, "R2 before hold");
        for (int k = 0; k < 3; k++) begin
            op_a = rnd_fe(); op_b = rnd_fe(); sq_mode = ~sq_mode;
            @(negedge clk);
            check(result == e, "R9 result held", result, e);
            check(done == 1'b0, "R8 no done without start", {162'd0, done}, 163'd0);
        end
    endtask

    task automatic t_back_to_back();
        logic [162:0] a1 = rnd_fe();
        logic [162:0] b1 = rnd_fe();
        logic [162:0] a2 = rnd_fe();
        @(negedge clk);
        sq_mode = 1'b0; op_a = a1; op_b = b1; start = 1'b1;
        @(negedge clk);
        sq_mode = 1'b1; op_a = a2;
        check(done == 1'b1, "R10 first done", {162'd0, done}, 163'd1);
        check(result == ref_mul(a1, b1), "R10 first result", result, ref_mul(a1, b1));
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1, "R10 second done", {162'd0, done}, 163'd1);
        check(result == ref_mul(a2, a2), "R10 second result", result, ref_mul(a2, a2));
        @(negedge clk);
        check(done == 1'b0, "R8 done drops", {162'd0, done}, 163'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_identity();
        t_zero();
        t_allones();
        t_top_fold();
        t_random();
        t_square();
        t_hold();
        t_back_to_back();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule